// File: doc/BRIEF.md
# Paged Indirect Operand Address Resolver

This block turns the operand field of an instruction into a final 15-bit word address. A direct operand is a 10-bit offset. It is placed absolutely, not relative to the program counter, inside one of two pages of 1024 words: the page that holds the instruction, or page zero. Any other target is reached through pointer words held in memory. When the instruction's indirect flag is set, the resolver reads the word at the direct address. If that word's top bit is set, its low 15 bits name the next pointer word, and the walk goes on. The walk stops at the first word whose top bit is clear, and that word's low 15 bits are the result.

Memory is reached through a plain synchronous read port. The port returns data exactly one cycle after a request, and the resolver makes one read for each level of indirection. A configurable depth limit ends endless pointer loops and raises an error flag. A separate combinational path serves byte-oriented accesses. It splits a 16-bit byte address into a word address and a byte lane.

Top module: `addr_resolver`

## Requirements
- R1: While reset is asserted and after reset is released, `done_o`, `err_o`, `mem_req_o` and `ea_o` are all zero.
- R2: If a start is accepted with `indirect_i` low and `page_zero_i` low, `done_o` is high in the next cycle with `ea_o` = {`pc_page_i`, `offset_i`}. `err_o` stays low and no memory read is made.
- R3: If a start is accepted with `page_zero_i` high, the direct address is {zeros, `offset_i`}. With `indirect_i` low, that address appears on `ea_o` with `done_o` in the next cycle.
- R4: If a start is accepted with `indirect_i` high, `mem_req_o` is high for exactly one cycle, in the cycle after the start, with `mem_addr_o` equal to the direct address. The returned word is sampled one cycle after the request. Each level of indirection makes exactly one read.
- R5: A fetched word with bit 15 set causes a new one-cycle request, in the cycle after its data arrives, at its bits 14:0. The first fetched word with bit 15 clear ends the walk. `done_o` is then high in the next cycle with `ea_o` = that word's bits 14:0 and `err_o` low. A walk of k reads completes 2k+1 cycles after the start.
- R6: At most MAX_DEPTH reads (16 by default) are made. If the MAX_DEPTH-th fetched word still has bit 15 set, `done_o` and `err_o` are high together and no further read is made. A walk whose MAX_DEPTH-th word has bit 15 clear completes without error.
- R7: A start that arrives while a resolution is in progress is ignored. The walk in progress and its result are unchanged.
- R8: `done_o` is high for one cycle for each resolution. `ea_o` changes only in a cycle where `done_o` is high without `err_o`, and it holds its value until the next such cycle.
- R9: `byte_word_o` = `byte_addr_i` >> 1 and `byte_lane_o` = bit 0 of `byte_addr_i`. Lane 0 is the even byte, which sits in word bits 15:8. Lane 1 is the odd byte, in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a resolution (used only when idle) |
| indirect_i | input | 1 | Operand is a pointer to be followed |
| page_zero_i | input | 1 | Use page zero instead of the current page |
| offset_i | input | 10 | Offset inside the selected page |
| pc_page_i | input | 5 | Page number of the program counter |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 15 | Memory read word address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the request |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Depth limit reached (valid with done) |
| ea_o | output | 15 | Resolved effective word address |
| byte_addr_i | input | 16 | Byte address for the byte path |
| byte_word_o | output | 15 | Word address holding that byte |
| byte_lane_o | output | 1 | Byte lane: 0 even (bits 15:8), 1 odd (bits 7:0) |

## Verification
Direct operands are tried in both the current page and page zero, at the extreme offsets and page numbers. These cases separate concatenation from addition and show that the page select is honoured. Indirect walks of one, three and sixteen levels, with pointers that cross pages, show that each hop uses the fetched low bits and not the instruction page. The sixteen-level walk and a self-pointing word mark the exact edge between a valid result and the depth error. A start injected in the middle of a walk, and byte addresses at both ends of the range and at both parities, cover the busy-ignore and lane rules.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ar_state_e;
endpackage

// File: rtl/ar_direct.sv
module ar_direct #(
  parameter int ADDR_W = 15,
  parameter int OFFS_W = 10,
  localparam int PAGE_W = ADDR_W - OFFS_W
) (
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [PAGE_W-1:0] pc_page_i,
  input  logic              page_zero_i,
  output logic [ADDR_W-1:0] addr_o
);
  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [PAGE_W-1:0] page,
    input logic              zero_sel,
    input logic [OFFS_W-1:0] offs
  );
    logic [PAGE_W-1:0] pg;
    pg = zero_sel ? '0 : page;
    return {pg, offs};
  endfunction

  assign addr_o = form_addr(pc_page_i, page_zero_i, offset_i);
endmodule

// File: rtl/ar_byte_split.sv
module ar_byte_split #(
  parameter int ADDR_W = 15,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic [BYTE_W-1:0] byte_addr_i,
  output logic [ADDR_W-1:0] word_o,
  output logic              lane_o
);
  function automatic logic [ADDR_W-1:0] word_of(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1];
  endfunction

  assign word_o = word_of(byte_addr_i);
  assign lane_o = byte_addr_i[0];
endmodule

// File: rtl/ar_chain.sv
module ar_chain
  import ar_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int MAX_DEPTH = 16,
  localparam int DATA_W   = ADDR_W + 1,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              indirect_i,
  input  logic [ADDR_W-1:0] direct_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] ea_o
);
  ar_state_e          state;
  logic [ADDR_W-1:0]  ptr;
  logic [DEPTH_W-1:0] depth;

  // named internal events
  logic accept, word_chains, chain_end, limit_hit, busy_start;
  assign accept      = start_i && (state == ST_IDLE);
  assign busy_start  = start_i && (state != ST_IDLE);
  assign word_chains = mem_rdata_i[DATA_W-1];
  assign chain_end   = (state == ST_WAIT) && !word_chains;
  assign limit_hit   = (state == ST_WAIT) && word_chains && (depth == DEPTH_W'(MAX_DEPTH));

  function automatic logic [ADDR_W-1:0] link_of(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      depth  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      ea_o   <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (indirect_i) begin
              ptr   <= direct_addr_i;
              depth <= '0;
              state <= ST_REQ;
            end else begin
              ea_o   <= direct_addr_i;
              done_o <= 1'b1;
            end
          end
        end
        ST_REQ: begin
          depth <= depth + DEPTH_W'(1);
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (chain_end) begin
            ea_o   <= link_of(mem_rdata_i);
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else if (limit_hit) begin
            err_o  <= 1'b1;
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            ptr   <= link_of(mem_rdata_i);
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state == ST_REQ);
  assign mem_addr_o = ptr;

  AST_DIRECT_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !indirect_i) |=> (done_o && !err_o && !mem_req_o && ea_o == $past(direct_addr_i))); // R2
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && indirect_i) |=> (mem_req_o && mem_addr_o == $past(direct_addr_i))); // R4
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o); // R4
  AST_NEXT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT) && word_chains && !limit_hit) |=>
      (mem_req_o && mem_addr_o == $past(mem_rdata_i[ADDR_W-1:0]))); // R5
  AST_END_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end |=> (done_o && !err_o && ea_o == $past(mem_rdata_i[ADDR_W-1:0]))); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R6
  AST_LIMIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |=> (err_o && !mem_req_o)); // R6
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DEPTH_W'(MAX_DEPTH)); // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_start && state == ST_REQ) |=> (state == ST_WAIT)); // R7
  AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o || err_o) |-> $stable(ea_o)); // R8
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver #(
  parameter int ADDR_W    = 15,
  parameter int OFFS_W    = 10,
  parameter int MAX_DEPTH = 16,
  localparam int PAGE_W   = ADDR_W - OFFS_W,
  localparam int DATA_W   = ADDR_W + 1,
  localparam int BYTE_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              indirect_i,
  input  logic              page_zero_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [PAGE_W-1:0] pc_page_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] ea_o,
  input  logic [BYTE_W-1:0] byte_addr_i,
  output logic [ADDR_W-1:0] byte_word_o,
  output logic              byte_lane_o
);
  logic [ADDR_W-1:0] direct_addr;

  ar_direct #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_direct (
    .offset_i    (offset_i),
    .pc_page_i   (pc_page_i),
    .page_zero_i (page_zero_i),
    .addr_o      (direct_addr)
  );

  ar_chain #(.ADDR_W(ADDR_W), .MAX_DEPTH(MAX_DEPTH)) u_chain (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .indirect_i    (indirect_i),
    .direct_addr_i (direct_addr),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rdata_i   (mem_rdata_i),
    .done_o        (done_o),
    .err_o         (err_o),
    .ea_o          (ea_o)
  );

  ar_byte_split #(.ADDR_W(ADDR_W)) u_bytes (
    .byte_addr_i (byte_addr_i),
    .word_o      (byte_word_o),
    .lane_o      (byte_lane_o)
  );

  AST_PAGE_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && page_zero_i) |-> (direct_addr[ADDR_W-1:OFFS_W] == '0)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!done_o && !err_o && !mem_req_o && ea_o == '0)); // R1
endmodule

// File: tb/test_addr_resolver.sv
module test_addr_resolver;
  localparam int MAXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ind = 1'b0, pz = 1'b0;
  logic [9:0]  off = '0;
  logic [4:0]  page = '0;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        done, err;
  logic [14:0] ea;
  logic [15:0] baddr = '0;
  logic [14:0] bword;
  logic        blane;

  always #2.5 clk = ~clk;

  addr_resolver i_addr_resolver (
    .clk(clk), .rst_n(rst_n), .start_i(start), .indirect_i(ind), .page_zero_i(pz),
    .offset_i(off), .pc_page_i(page), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .done_o(done), .err_o(err), .ea_o(ea),
    .byte_addr_i(baddr), .byte_word_o(bword), .byte_lane_o(blane)
  );

  logic [15:0] mem [int];
  function automatic logic [15:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction
  always @(posedge clk) if (mem_req) mem_rdata <= rd(int'(mem_addr));

  int errors = 0, checks = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: whole walk computed at acceptance, then replayed by cycle index
  bit m_active = 0, m_err = 0;
  int t = 0, n = 0;
  int q_addr[$];
  int m_ea = 0, held_ea = 0;

  always @(posedge clk) begin
    bit busy;
    if (!rst_n) begin
      m_active = 0; t = 0; n = 0;
    end else begin
      busy = m_active && (t < 2*n+1);
      if (m_active) t++;
      if (start && !busy) begin
        int a;
        a = pz ? int'(off) : int'(page)*1024 + int'(off);
        q_addr.delete(); m_err = 0;
        if (!ind) m_ea = a;
        else begin
          forever begin
            int w;
            q_addr.push_back(a);
            w = int'(rd(a));
            if (w < 'h8000) begin m_ea = w; break; end
            if (q_addr.size() == MAXD) begin m_err = 1; break; end
            a = w & 'h7FFF;
          end
        end
        n = q_addr.size(); t = 1; m_active = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit er, ed;
      int ea_exp;
      er = m_active && (t < 2*n+1) && (t % 2 == 1);
      ed = m_active && (t == 2*n+1);
      if (ed && !m_err) held_ea = m_ea;
      check(mem_req == er, "mem_req", mem_req, er);
      if (er) begin
        ea_exp = q_addr[(t-1)/2];
        check(int'(mem_addr) == ea_exp, "mem_addr", mem_addr, ea_exp);
      end
      check(done == ed, "done", done, ed);
      check(err == (ed && m_err), "err", err, ed && m_err);
      check(int'(ea) == held_ea, "ea", ea, held_ea);
    end
  end

  function automatic bit model_busy();
    return m_active && (t < 2*n+1);
  endfunction

  task automatic op(input bit p0, input bit indir, input int o, input int pg);
    @(negedge clk);
    pz = p0; ind = indir; off = 10'(o); page = 5'(pg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (model_busy()) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bcheck(input int b);
    @(negedge clk);
    baddr = 16'(b);
    #1;
    check(int'(bword) == b / 2, "byte_word", bword, b / 2);
    check(blane == 1'(b % 2), "byte_lane", blane, b % 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    check(!done && !err && !mem_req && ea == 0, "reset outputs", {done, err, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !err && !mem_req && ea == 0, "after reset", int'(ea), 0);

    tag = "R2";
    op(0, 0, 'h123, 5);
    op(0, 0, 'h3FF, 31);
    op(0, 0, 0, 0);
    tag = "R3";
    op(1, 0, 'h2AA, 17);
    op(1, 0, 'h3FF, 31);

    tag = "R4";
    mem[3*1024 + 'h010] = 16'h1234;
    op(0, 1, 'h010, 3);
    mem['h005] = 16'h7FFF;
    op(1, 1, 5, 9);

    tag = "R5";
    mem['h0020] = 16'h8000 | 16'h4321;
    mem['h4321] = 16'h8000 | 16'h7000;
    mem['h7000] = 16'h0ABC;
    op(1, 1, 'h20, 0);

    tag = "R6";
    for (int i = 0; i < MAXD; i++)
      mem['h6000 + i] = (i < MAXD-1) ? 16'(32'h8000 | ('h6001 + i)) : 16'h0555;
    op(0, 1, 0, 24);
    mem['h0900] = 16'h8900;
    op(0, 1, 'h100, 2);

    tag = "R7";
    @(negedge clk);
    pz = 1; ind = 1; off = 10'h20; page = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    pz = 0; ind = 0; off = 10'h3A5; page = 7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (model_busy()) @(negedge clk);
    @(negedge clk);

    tag = "R8";
    op(0, 0, 'h001, 1);
    repeat (4) @(negedge clk);
    op(0, 1, 'h100, 2);
    repeat (3) @(negedge clk);

    tag = "R9";
    bcheck('h0000);
    bcheck('hFFFF);
    bcheck('h1235);
    bcheck('h8000);
    bcheck('h7FFE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule